// File: doc/BRIEF.md
# Time-Division Duplex Frame Sequencer

This block is a counter-driven waveform generator. It drives a set of gated output lanes that switch transmit/receive paths in a time-division duplex radio, or that time any other logic in the chip. Software, through a register file outside this block, sets a startup delay, a frame length in clock cycles, a burst length and per-lane switch points. It then raises the run enable. The block arms, waits for a single-cycle sync pulse from an external sync source, counts out the startup delay and then plays frames back to back.

Within each frame every lane turns active when the in-frame position reaches its ON offset and inactive when it reaches its OFF offset. A lane can be masked, and its final level can be inverted. A burst length of zero means frames repeat until the enable drops. Any other value plays exactly that many frames and then returns to the armed state. An optional mode lets a sync pulse that arrives mid-run snap the frame back to its first cycle. The sequencer state is brought out as a two-bit code for status readback.

Top module: `duplex_frame_seq`

## Requirements
- R1: While `rst` is high, `fsm_state` is 0 and every `ch_out` bit is 0. Two clocks after reset is released, with `run_en` low, each `ch_out` bit equals its `ch_invert` bit.
- R2: State codes are IDLE=0, ARMED=1, WAITING=2 and RUNNING=3. With `run_en` high, IDLE moves to ARMED on the next clock. ARMED holds until `sync_pulse` is seen.
- R3: A sync pulse seen in ARMED with startup delay D>0 gives exactly D cycles of WAITING, followed by RUNNING. With D=0 the state goes straight to RUNNING on the next clock. The first RUNNING cycle is in-frame position 0.
- R4: In RUNNING the in-frame position counts 0 to L-1 and then restarts at 0, where L is the frame length in cycles. A frame length of 0 behaves as 1.
- R5: An enabled lane turns active in the cycle whose position equals its ON offset and turns inactive in the cycle whose position equals its OFF offset. Its level carries across frame boundaries. Each run starts with the lane inactive.
- R6: A lane whose ON and OFF offsets are equal stays inactive. An offset at or beyond the frame length never takes effect.
- R7: `ch_out` equals the lane's activity XOR its invert bit. A lane whose enable bit is 0 holds its inactive level. Every lane holds its inactive level whenever the state is not RUNNING.
- R8: With burst length N≠0 the sequencer plays exactly N frames and then enters ARMED. With N=0 it stays RUNNING for as long as `run_en` stays high.
- R9: In RUNNING with `sync_restart` high, a sync pulse makes the next cycle position 0. This takes priority over the end of a frame, and the cut frame is not counted toward the burst. A sync pulse is ignored in WAITING, and ignored in RUNNING when `sync_restart` is low.
- R10: `run_en` low moves any state to IDLE on the next clock, with all lanes at their inactive level.
- R11: Startup delay, frame length, burst length, offsets, lane enables and invert bits are captured only while the state is IDLE. Changes to these inputs while the state is not IDLE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low forces IDLE |
| sync_pulse | input | 1 | Single-cycle sync event |
| sync_restart | input | 1 | Let a sync pulse restart the frame while RUNNING |
| startup_delay | input | CNT_W | Cycles of WAITING before the first frame |
| frame_len | input | CNT_W | Frame length in cycles (0 acts as 1) |
| burst_len | input | BURST_W | Frames per burst, 0 = endless |
| ch_enable | input | NUM_CH | Per-lane enable |
| ch_invert | input | NUM_CH | Per-lane output inversion |
| ch_on_ofs | input | NUM_CH*CNT_W | Per-lane ON position, lane k in bits [k*CNT_W +: CNT_W] |
| ch_off_ofs | input | NUM_CH*CNT_W | Per-lane OFF position, same packing |
| ch_out | output | NUM_CH | Registered lane outputs |
| fsm_state | output | 2 | Registered state code (see R2) |

## Verification
Two functions can land on the same clock edge: a sync-triggered frame restart and the natural end of the last frame of a finite burst. The bench provokes this by issuing the second sync pulse exactly on the final cycle of the final frame. It judges the result by requiring the state to stay RUNNING for one more complete frame, rather than dropping to ARMED at once, with lane levels continuing as if the frame had wrapped normally. A second overlap is a lane whose ON and OFF offsets fall on the same position. The sweep includes such a lane in every configuration and expects it to stay at its inactive level.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } dfs_state_e;
endpackage

// File: rtl/dfs_cfg_hold.sv
// Shadow copy of the timing settings; loads only while the sequencer idles.
module dfs_cfg_hold #(
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [CNT_W-1:0]         in_dly,
  input  logic [CNT_W-1:0]         in_flen,
  input  logic [BURST_W-1:0]       in_burst,
  input  logic [NUM_CH-1:0]        in_en,
  input  logic [NUM_CH-1:0]        in_inv,
  input  logic [NUM_CH*CNT_W-1:0]  in_on,
  input  logic [NUM_CH*CNT_W-1:0]  in_off,
  output logic [CNT_W-1:0]         q_dly,
  output logic [CNT_W-1:0]         q_flen,
  output logic [BURST_W-1:0]       q_burst,
  output logic [NUM_CH-1:0]        q_en,
  output logic [NUM_CH-1:0]        q_inv,
  output logic [NUM_CH*CNT_W-1:0]  q_on,
  output logic [NUM_CH*CNT_W-1:0]  q_off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_dly   <= '0;
      q_flen  <= '0;
      q_burst <= '0;
      q_en    <= '0;
      q_inv   <= '0;
      q_on    <= '0;
      q_off   <= '0;
    end else if (load) begin
      q_dly   <= in_dly;
      q_flen  <= in_flen;
      q_burst <= in_burst;
      q_en    <= in_en;
      q_inv   <= in_inv;
      q_on    <= in_on;
      q_off   <= in_off;
    end
  end
endmodule

// File: rtl/dfs_timeline.sv
// Sequencer state machine with startup, in-frame and burst counters.
module dfs_timeline
  import dfs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               sync_pulse,
  input  logic               sync_restart,
  input  logic [CNT_W-1:0]   dly,
  input  logic [CNT_W-1:0]   flen,
  input  logic [BURST_W-1:0] burst,
  output dfs_state_e         st_q,
  output dfs_state_e         st_nxt,
  output logic [CNT_W-1:0]   pos_nxt
);
  localparam int EW = CNT_W + 1;
  localparam int BW = BURST_W + 1;

  logic [CNT_W-1:0]   pos_q, dcnt_q, dcnt_nxt;
  logic [BURST_W-1:0] bcnt_q, bcnt_nxt;
  logic               frame_last, dly_last, burst_last, restart_hit;

  // frame_len 0 compares as "last" on every cycle, i.e. a one-cycle frame
  assign frame_last  = ({1'b0, pos_q} + EW'(1)) >= {1'b0, flen};
  assign dly_last    = ({1'b0, dcnt_q} + EW'(1)) >= {1'b0, dly};
  assign burst_last  = (burst != '0) && (({1'b0, bcnt_q} + BW'(1)) == {1'b0, burst});
  assign restart_hit = sync_pulse && sync_restart;

  always_comb begin
    st_nxt   = st_q;
    pos_nxt  = pos_q;
    dcnt_nxt = dcnt_q;
    bcnt_nxt = bcnt_q;
    if (!run_en) begin
      st_nxt  = ST_IDLE;
      pos_nxt = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_nxt = ST_ARMED;
        ST_ARMED: begin
          if (sync_pulse) begin
            pos_nxt  = '0;
            dcnt_nxt = '0;
            bcnt_nxt = '0;
            st_nxt   = (dly == '0) ? ST_RUN : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dly_last) begin
            st_nxt  = ST_RUN;
            pos_nxt = '0;
          end else begin
            dcnt_nxt = dcnt_q + CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (restart_hit) begin
            pos_nxt = '0;
          end else if (frame_last) begin
            pos_nxt = '0;
            if (burst_last) st_nxt = ST_ARMED;
            else if (burst != '0) bcnt_nxt = bcnt_q + BURST_W'(1);
          end else begin
            pos_nxt = pos_q + CNT_W'(1);
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      dcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      st_q   <= st_nxt;
      pos_q  <= pos_nxt;
      dcnt_q <= dcnt_nxt;
      bcnt_q <= bcnt_nxt;
    end
  end
endmodule

// File: rtl/dfs_lane.sv
// One output lane: set/clear comparators on the next frame position.
module dfs_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_nxt,
  input  logic [CNT_W-1:0] pos_nxt,
  input  logic             en,
  input  logic             inv,
  input  logic [CNT_W-1:0] on_ofs,
  input  logic [CNT_W-1:0] off_ofs,
  output logic             out_q
);
  logic act_q, act_nxt;

  always_comb begin
    if (!run_nxt || !en)          act_nxt = 1'b0;
    else if (pos_nxt == off_ofs)  act_nxt = 1'b0;
    else if (pos_nxt == on_ofs)   act_nxt = 1'b1;
    else                          act_nxt = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      act_q <= act_nxt;
      out_q <= act_nxt ^ inv;
    end
  end
endmodule

// File: rtl/duplex_frame_seq.sv
module duplex_frame_seq
  import dfs_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CNT_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic                     sync_pulse,
  input  logic                     sync_restart,
  input  logic [CNT_W-1:0]         startup_delay,
  input  logic [CNT_W-1:0]         frame_len,
  input  logic [BURST_W-1:0]       burst_len,
  input  logic [NUM_CH-1:0]        ch_enable,
  input  logic [NUM_CH-1:0]        ch_invert,
  input  logic [NUM_CH*CNT_W-1:0]  ch_on_ofs,
  input  logic [NUM_CH*CNT_W-1:0]  ch_off_ofs,
  output logic [NUM_CH-1:0]        ch_out,
  output logic [1:0]               fsm_state
);
  localparam int OFS_W = NUM_CH * CNT_W;

  logic [CNT_W-1:0]   held_dly, held_flen, pos_nxt;
  logic [BURST_W-1:0] held_burst;
  logic [NUM_CH-1:0]  held_en, held_inv;
  logic [OFS_W-1:0]   held_on, held_off;
  dfs_state_e         st_q, st_nxt;
  logic               run_nxt;

  dfs_cfg_hold #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_cfg (
    .clk(clk), .rst(rst), .load(st_q == ST_IDLE),
    .in_dly(startup_delay), .in_flen(frame_len), .in_burst(burst_len),
    .in_en(ch_enable), .in_inv(ch_invert), .in_on(ch_on_ofs), .in_off(ch_off_ofs),
    .q_dly(held_dly), .q_flen(held_flen), .q_burst(held_burst),
    .q_en(held_en), .q_inv(held_inv), .q_on(held_on), .q_off(held_off)
  );

  dfs_timeline #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_tl (
    .clk(clk), .rst(rst), .run_en(run_en), .sync_pulse(sync_pulse),
    .sync_restart(sync_restart), .dly(held_dly), .flen(held_flen),
    .burst(held_burst), .st_q(st_q), .st_nxt(st_nxt), .pos_nxt(pos_nxt)
  );

  assign run_nxt   = (st_nxt == ST_RUN);
  assign fsm_state = st_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    dfs_lane #(.CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst), .run_nxt(run_nxt), .pos_nxt(pos_nxt),
      .en(held_en[k]), .inv(held_inv[k]),
      .on_ofs(held_on[k*CNT_W +: CNT_W]), .off_ofs(held_off[k*CNT_W +: CNT_W]),
      .out_q(ch_out[k])
    );
  end
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              sync_pulse,
  input logic [1:0]        fsm_state,
  input logic [NUM_CH-1:0] ch_out,
  input logic [NUM_CH-1:0] cfg_inv,
  input logic [NUM_CH-1:0] cfg_en,
  input logic [CNT_W-1:0]  cfg_flen,
  input logic [CNT_W-1:0]  cfg_dly
);
  AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> fsm_state == 2'd0); // R10
  AST_IDLE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 2'd0 && run_en) |=> fsm_state == 2'd1); // R2
  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 2'd1 && run_en && !sync_pulse) |=> fsm_state == 2'd1); // R2
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 2'd2 && run_en) |=> (fsm_state == 2'd2 || fsm_state == 2'd3)); // R3
  AST_RUN_EXIT: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 2'd3 && run_en) |=> (fsm_state == 2'd3 || fsm_state == 2'd1)); // R8
  AST_PARKED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ((fsm_state == 2'd1 || fsm_state == 2'd2) && $past(fsm_state) != 2'd0)
      |-> ch_out == cfg_inv); // R7
  AST_MASKED_LANE: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != 2'd0 && $past(fsm_state) != 2'd0)
      |-> ((ch_out ^ cfg_inv) & ~cfg_en) == '0); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != 2'd0) |=> ($stable(cfg_flen) && $stable(cfg_dly))); // R11
endmodule

bind duplex_frame_seq dfs_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .sync_pulse(sync_pulse),
  .fsm_state(fsm_state), .ch_out(ch_out), .cfg_inv(held_inv),
  .cfg_en(held_en), .cfg_flen(held_flen), .cfg_dly(held_dly)
);

// File: tb/duplex_frame_seq_tb.sv
module duplex_frame_seq_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CW    = 6;
  localparam int BWD   = 4;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic              rst, run_en, sync_pulse, sync_restart;
  logic [CW-1:0]     startup_delay, frame_len;
  logic [BWD-1:0]    burst_len;
  logic [NCH-1:0]    ch_enable, ch_invert, ch_out;
  logic [NCH*CW-1:0] ch_on_ofs, ch_off_ofs;
  logic [1:0]        fsm_state;

  int vectors = 0;
  int fails   = 0;
  int g_on[NCH];
  int g_off[NCH];
  logic [NCH-1:0] g_en, g_inv;
  int g_L, g_D, g_N;

  duplex_frame_seq #(.NUM_CH(NCH), .CNT_W(CW), .BURST_W(BWD)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .sync_pulse(sync_pulse),
    .sync_restart(sync_restart), .startup_delay(startup_delay),
    .frame_len(frame_len), .burst_len(burst_len), .ch_enable(ch_enable),
    .ch_invert(ch_invert), .ch_on_ofs(ch_on_ofs), .ch_off_ofs(ch_off_ofs),
    .ch_out(ch_out), .fsm_state(fsm_state)
  );

  // largest index i <= n with i mod L == x, or -1
  function automatic int last_hit(int n, int L, int x);
    int p, r;
    if (x >= L) return -1;
    p = n % L;
    if (x <= p) return n - p + x;
    r = n - p - L + x;
    return (r >= 0) ? r : -1;
  endfunction

  function automatic bit lane_on(int n, int L, int on, int off);
    int a, b;
    a = last_hit(n, L, on);
    b = last_hit(n, L, off);
    return (on != off) && (a >= 0) && (a > b);
  endfunction

  task automatic chk(int got, int exp, string tag, string what);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // n < 0 means not running; Le is the effective frame length
  task automatic chk_lanes(int n, int Le, string tag);
    for (int c = 0; c < NCH; c++) begin
      bit e;
      string t;
      e = ((n >= 0) && g_en[c] && lane_on(n, Le, g_on[c], g_off[c])) ^ g_inv[c];
      if (!g_en[c]) t = "R7";
      else if (g_on[c] == g_off[c] || g_on[c] >= Le || g_off[c] >= Le) t = "R6";
      else t = tag;
      chk(int'(ch_out[c]), int'(e), t, $sformatf("lane %0d", c));
    end
  endtask

  task automatic drive_cfg();
    startup_delay = CW'(g_D);
    frame_len     = CW'(g_L);
    burst_len     = BWD'(g_N);
    ch_enable     = g_en;
    ch_invert     = g_inv;
    for (int c = 0; c < NCH; c++) begin
      ch_on_ofs[c*CW +: CW]  = CW'(g_on[c]);
      ch_off_ofs[c*CW +: CW] = CW'(g_off[c]);
    end
  endtask

  task automatic scramble_cfg();
    startup_delay = CW'(g_D + 2);
    frame_len     = CW'(g_L + 2);
    burst_len     = BWD'(g_N + 1);
    ch_enable     = ~g_en;
    ch_invert     = ~g_inv;
    for (int c = 0; c < NCH; c++) begin
      ch_on_ofs[c*CW +: CW]  = CW'(2);
      ch_off_ofs[c*CW +: CW] = CW'(0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lens[6];
    int dlys[3];
    int bursts[3];
    int run;
    lens = '{0, 1, 2, 3, 5, 7};
    dlys = '{0, 1, 3};
    bursts = '{0, 1, 3};
    rst = 1'b1; run_en = 1'b0; sync_pulse = 1'b0; sync_restart = 1'b0;
    g_L = 4; g_D = 0; g_N = 0; g_en = '1; g_inv = 4'b1010;
    for (int c = 0; c < NCH; c++) begin g_on[c] = 0; g_off[c] = 1; end
    drive_cfg();
    repeat (3) @(negedge clk);
    chk(int'(fsm_state), 0, "R1", "state in reset");
    chk(int'(ch_out), 0, "R1", "lanes in reset");
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(int'(fsm_state), 0, "R1", "state after reset");
    chk(int'(ch_out), 10, "R1", "lanes after reset");

    // sweep: frame length x startup delay x burst length
    run = 0;
    for (int li = 0; li < 6; li++)
      for (int di = 0; di < 3; di++)
        for (int bi = 0; bi < 3; bi++) begin
          int Le, win;
          g_L = lens[li]; g_D = dlys[di]; g_N = bursts[bi];
          Le = (g_L == 0) ? 1 : g_L;
          g_on[0] = 0;      g_off[0] = (Le > 1) ? Le - 1 : 0;
          g_on[1] = Le - 1; g_off[1] = Le / 2;
          g_on[2] = Le / 2; g_off[2] = Le / 2;
          g_on[3] = 1;      g_off[3] = Le + 1;
          g_en  = (run % 3 == 0) ? 4'b0111 : (run % 3 == 1) ? 4'b1101 : 4'b1111;
          g_inv = NCH'(run % 16);
          run++;
          run_en = 1'b0; sync_pulse = 1'b0; sync_restart = 1'b0;
          drive_cfg();
          @(negedge clk); @(negedge clk);
          chk(int'(fsm_state), 0, "R10", "idle before arming");
          run_en = 1'b1;
          @(negedge clk);
          chk(int'(fsm_state), 1, "R2", "armed after enable");
          scramble_cfg();
          @(negedge clk); @(negedge clk);
          chk(int'(fsm_state), 1, "R2", "armed waits for sync");
          chk_lanes(-1, Le, "R11");
          sync_pulse = 1'b1;
          @(negedge clk);
          win = g_D + ((g_N == 0) ? 3 : g_N) * Le + 3;
          for (int j = 1; j <= win; j++) begin
            int es;
            string tg;
            sync_pulse = 1'b0;
            if (j <= g_D) begin es = 2; tg = "R3"; end
            else if (g_N != 0 && j > g_D + g_N * Le) begin es = 1; tg = "R8"; end
            else begin es = 3; tg = "R4"; end
            if (j == g_D + 3 || (g_D == 3 && j == 3)) tg = "R9";
            chk(int'(fsm_state), es, tg, "state");
            chk_lanes((es == 3) ? j - g_D - 1 : -1, Le, (tg == "R9") ? "R9" : "R5");
            // syncs that must be ignored: in WAITING, and in RUNNING without restart
            if ((g_D == 3 && j == 2) || (j == g_D + 2 && (g_N == 0 || g_N * Le >= 2)))
              sync_pulse = 1'b1;
            @(negedge clk);
          end
          sync_pulse = 1'b0;
          run_en = 1'b0;
          @(negedge clk);
          chk(int'(fsm_state), 0, "R10", "idle after enable drop");
          chk_lanes(-1, Le, "R10");
        end

    // R9: restart sync on the final cycle of the final burst frame
    run_en = 1'b0; sync_restart = 1'b1;
    g_L = 5; g_D = 0; g_N = 2;
    g_on[0] = 1; g_off[0] = 3;
    g_on[1] = 3; g_off[1] = 1;
    g_on[2] = 0; g_off[2] = 2;
    g_on[3] = 0; g_off[3] = 0;
    g_en = 4'b1011; g_inv = 4'b0100;
    drive_cfg();
    @(negedge clk); @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    chk(int'(fsm_state), 1, "R2", "armed for restart case");
    sync_pulse = 1'b1;
    @(negedge clk);
    for (int j = 1; j <= 18; j++) begin
      int es, n;
      sync_pulse = 1'b0;
      if (j <= 10)      begin es = 3; n = j - 1; end
      else if (j <= 15) begin es = 3; n = j - 11 + 5; end
      else              begin es = 1; n = -1; end
      chk(int'(fsm_state), es, "R9", "state around restart collision");
      chk_lanes(n, 5, "R9");
      if (j == 10) sync_pulse = 1'b1;
      @(negedge clk);
    end
    sync_pulse = 1'b0;
    run_en = 1'b0;
    @(negedge clk);
    chk(int'(fsm_state), 0, "R10", "idle after restart case");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule